// File: doc/BRIEF.md
# Edge-Configurable Vectored Interrupt Controller

This block collects interrupt events from sixteen external lines. Each line passes through a two-stage synchronizer. An edge detector then follows, and a per-line configuration bit sets it to react to a falling transition only, or to any transition. A detected event latches a pending bit. Software clears a pending bit by writing a one to it. An enable register gates the pending bits. The request output goes high whenever an enabled bit is pending.

A vector register reports the highest-priority enabled pending source. Line 0 ranks highest. The code for line n is n+1, and code 0 means that nothing is requested. The code sits in the top six bits of the 32-bit word. A byte read of the top byte therefore returns code×4, which is a stride of four bytes between table entries. A halfword read of the top halfword returns code×0x400, which is a stride of 1 KB between routines. While a read of the vector is in progress, the vector does not change. It picks up the current winner on the first cycle after the read ends.

Software reaches four word registers through a simple register bus. The bus has a select, separate read and write strobes, a 2-bit word address and a registered read-data path. The address map is: 0 edge configuration, 1 enable, 2 pending, 3 vector.

Top module: `edge_vec_intc`

## Requirements
- R1: After reset, the edge configuration, enable, pending and vector registers all read 0, and `irq_o` is 0. No event is recorded while the synchronizer fills after reset.
- R2: With configuration bit n at 0, a high-to-low transition on line n sets pending bit n. A low-to-high transition leaves it clear.
- R3: With configuration bit n at 1, both a falling and a rising transition on line n set pending bit n.
- R4: Writing 1 to bit n of the pending register (address 2) clears that bit. Writing 0 leaves it unchanged.
- R5: When an event on line n is detected in the same cycle as a write that clears bit n, the bit stays set. Other bits cleared by that write do clear.
- R6: `irq_o` is 1 exactly when some pending bit has its enable bit (address 1) at 1. Pending bits still latch while they are disabled.
- R7: The vector code is n+1 for the lowest-numbered line n that is both pending and enabled. It is 0 when no such line exists.
- R8: The vector word holds the code in bits [31:26], and all other bits are 0. Bits [31:24] read as code×4, and bits [31:16] read as code×0x400.
- R9: While a read of address 3 is held, the vector returned stays constant, even if a higher-priority source becomes pending. After the read ends, the next read returns the new winner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines_i | input | 16 | Asynchronous external interrupt lines |
| bus_sel_i | input | 1 | Register bus select |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe, held for the whole read access |
| bus_addr_i | input | 2 | Word address (0 edge cfg, 1 enable, 2 pending, 3 vector) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is R5. In that case the clear write must land on exactly the cycle in which a line's event leaves the synchronizer and edge detector. The bench toggles a line that is already pending on a falling clock edge. It counts two more falling edges and drives the clearing write there, so that the write and the detected event hit the pending register on the same rising edge. A second pending line cleared by the same write shows that the write itself took effect. R9 is reached in a similar way: the bench raises a higher-priority line partway through a read that it holds over many cycles.

// File: rtl/evi_pkg.sv
package evi_pkg;
  localparam int BUS_DW  = 32;
  localparam int REG_AW  = 2;
  localparam int VEC_FW  = 6;
  localparam int VEC_LSB = BUS_DW - VEC_FW;

  typedef enum logic [REG_AW-1:0] {
    RSEL_EDGE   = 2'd0,
    RSEL_ENABLE = 2'd1,
    RSEL_PEND   = 2'd2,
    RSEL_VEC    = 2'd3
  } rsel_e;

  // Place a source code in the top field so byte and halfword reads scale it
  function automatic logic [BUS_DW-1:0] pack_vector(input logic [VEC_FW-1:0] code);
    logic [BUS_DW-1:0] w;
    w = '0;
    w[BUS_DW-1:VEC_LSB] = code;
    return w;
  endfunction
endpackage

// File: rtl/evi_edge_detect.sv
module evi_edge_detect #(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic [NUM_LINES-1:0] any_edge_i,
  output logic [NUM_LINES-1:0] evt_o
);
  localparam int PRIME   = SYNC_STAGES + 1;
  localparam int PRIME_W = $clog2(PRIME + 1);

  logic [PRIME_W-1:0] prime_q;
  logic               armed;

  assign armed = (prime_q == PRIME_W'(PRIME));

  // Suppress events until the synchronizer and history flop hold real samples
  always_ff @(posedge clk) begin
    if (rst) begin
      prime_q <= '0;
    end else if (!armed) begin
      prime_q <= prime_q + 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;

    assign cur = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '0;
        prev_q <= 1'b0;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], pins_i[g]};
        prev_q <= cur;
      end
    end

    always_comb begin
      if (!armed) begin
        evt_o[g] = 1'b0;
      end else if (any_edge_i[g]) begin
        evt_o[g] = cur ^ prev_q;
      end else begin
        evt_o[g] = prev_q & ~cur;
      end
    end
  end
endmodule

// File: rtl/evi_pending.sv
module evi_pending #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] evt_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] pend_q;

  // A fresh event outranks a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_i) | evt_i;
    end
  end

  assign pend_o = pend_q;

  assert_set_needs_event_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt_i)) == '0));

  assert_event_beats_clear_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(evt_i)) == $past(evt_i)));

  assert_clear_drops_R4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend_q & $past(clr_i & ~evt_i)) == '0));
endmodule

// File: rtl/evi_prio_vec.sv
module evi_prio_vec #(
  parameter int NUM_LINES = 16,
  parameter int CODE_W    = $clog2(NUM_LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_LINES-1:0] hits_i,
  input  logic              hold_i,
  output logic [CODE_W-1:0] code_o,
  output logic              irq_o
);
  logic [CODE_W-1:0] code_nxt;
  logic [CODE_W-1:0] code_q;
  logic              irq_q;

  // Scan from the lowest priority up so the lowest index wins
  always_comb begin
    code_nxt = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (hits_i[i]) begin
        code_nxt = CODE_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= |hits_i;
      if (!hold_i) begin
        code_q <= code_nxt;
      end
    end
  end

  assign code_o = code_q;
  assign irq_o  = irq_q;

  assert_vec_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(code_q));

  assert_irq_matches_vec_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(hold_i) |-> (irq_q == (code_q != '0)));

  assert_code_is_winner_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(hold_i) && code_q != '0) |->
      (((NUM_LINES)'($past(hits_i)) >> (code_q - 1'b1)) & (NUM_LINES)'(1)) == (NUM_LINES)'(1));
endmodule

// File: rtl/edge_vec_intc.sv
module edge_vec_intc
  import evi_pkg::*;
#(
  parameter int NUM_LINES   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_lines_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_wr_i,
  input  logic                 bus_rd_i,
  input  logic [REG_AW-1:0]    bus_addr_i,
  input  logic [BUS_DW-1:0]    bus_wdata_i,
  output logic [BUS_DW-1:0]    bus_rdata_o,
  output logic                 irq_o
);
  localparam int CODE_W = $clog2(NUM_LINES + 1);

  rsel_e                rsel;
  logic                 wr_hit;
  logic                 rd_hit;
  logic                 vec_hold;
  logic [NUM_LINES-1:0] edge_cfg_q;
  logic [NUM_LINES-1:0] enable_q;
  logic [NUM_LINES-1:0] clr;
  logic [NUM_LINES-1:0] evt;
  logic [NUM_LINES-1:0] pend;
  logic [NUM_LINES-1:0] hits;
  logic [CODE_W-1:0]    code;
  logic [BUS_DW-1:0]    rdata_nxt;
  logic [BUS_DW-1:0]    rdata_q;

  assign rsel     = rsel_e'(bus_addr_i);
  assign wr_hit   = bus_sel_i & bus_wr_i;
  assign rd_hit   = bus_sel_i & bus_rd_i;
  assign vec_hold = rd_hit & (rsel == RSEL_VEC);
  assign clr      = (wr_hit && rsel == RSEL_PEND) ? bus_wdata_i[NUM_LINES-1:0] : '0;
  assign hits     = pend & enable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      edge_cfg_q <= '0;
      enable_q   <= '0;
    end else if (wr_hit) begin
      if (rsel == RSEL_EDGE)   edge_cfg_q <= bus_wdata_i[NUM_LINES-1:0];
      if (rsel == RSEL_ENABLE) enable_q   <= bus_wdata_i[NUM_LINES-1:0];
    end
  end

  evi_edge_detect #(
    .NUM_LINES  (NUM_LINES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk       (clk),
    .rst       (rst),
    .pins_i    (irq_lines_i),
    .any_edge_i(edge_cfg_q),
    .evt_o     (evt)
  );

  evi_pending #(
    .NUM_LINES(NUM_LINES)
  ) u_pend (
    .clk   (clk),
    .rst   (rst),
    .evt_i (evt),
    .clr_i (clr),
    .pend_o(pend)
  );

  evi_prio_vec #(
    .NUM_LINES(NUM_LINES),
    .CODE_W   (CODE_W)
  ) u_prio (
    .clk   (clk),
    .rst   (rst),
    .hits_i(hits),
    .hold_i(vec_hold),
    .code_o(code),
    .irq_o (irq_o)
  );

  always_comb begin
    rdata_nxt = '0;
    unique case (rsel)
      RSEL_EDGE:   rdata_nxt[NUM_LINES-1:0] = edge_cfg_q;
      RSEL_ENABLE: rdata_nxt[NUM_LINES-1:0] = enable_q;
      RSEL_PEND:   rdata_nxt[NUM_LINES-1:0] = pend;
      RSEL_VEC:    rdata_nxt = pack_vector(VEC_FW'(code));
      default:     rdata_nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_hit) begin
      rdata_q <= rdata_nxt;
    end else begin
      rdata_q <= '0;
    end
  end

  assign bus_rdata_o = rdata_q;

  assert_quiet_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (!irq_o && rdata_q == '0));
endmodule

// File: tb/tb_edge_vec_intc.sv
module tb_edge_vec_intc;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [N-1:0] lines = '1;
  logic        sel = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_vec_intc #(.NUM_LINES(N), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .irq_lines_i(lines),
    .bus_sel_i(sel), .bus_wr_i(wr), .bus_rd_i(rd), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = a;
    @(negedge clk);
    d = rdata;
    sel = 1'b0; rd = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] vec_of(input int code);
    return 32'(code) << 26;
  endfunction

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (8) @(negedge clk);

    // R1 reset state, lines idle high through reset
    chk("R1 irq", {31'd0, irq}, 32'd0);
    bus_read(2'd0, d); chk("R1 edge cfg", d, 32'd0);
    bus_read(2'd1, d); chk("R1 enable", d, 32'd0);
    bus_read(2'd2, d); chk("R1 pending", d, 32'd0);
    bus_read(2'd3, d); chk("R1 vector", d, 32'd0);

    // R2 falling-only mode, all disabled (R6 irq stays low)
    for (int i = 0; i < N; i++) begin
      @(negedge clk); lines[i] = 1'b0; settle();
      bus_read(2'd2, d); chk("R2 falling sets", d, 32'(1) << i);
      chk("R6 disabled no irq", {31'd0, irq}, 32'd0);
      if (i == 0) begin
        bus_write(2'd2, 32'd0);
        bus_read(2'd2, d); chk("R4 write zero keeps", d, 32'd1);
      end
      bus_write(2'd2, 32'(1) << i);
      bus_read(2'd2, d); chk("R4 w1c clears", d, 32'd0);
      @(negedge clk); lines[i] = 1'b1; settle();
      bus_read(2'd2, d); chk("R2 rising ignored", d, 32'd0);
    end

    // R3 any-edge mode
    bus_write(2'd0, 32'h0000_FFFF);
    for (int i = 0; i < N; i++) begin
      @(negedge clk); lines[i] = 1'b0; settle();
      bus_read(2'd2, d); chk("R3 fall sets", d, 32'(1) << i);
      bus_write(2'd2, 32'(1) << i);
      @(negedge clk); lines[i] = 1'b1; settle();
      bus_read(2'd2, d); chk("R3 rise sets", d, 32'(1) << i);
      bus_write(2'd2, 32'(1) << i);
    end

    // R7/R8 priority sweep with all enabled
    bus_write(2'd1, 32'h0000_FFFF);
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] m;
      m = ~N'((32'd1 << i) - 1);
      @(negedge clk); lines = lines ^ m; settle();
      chk("R6 irq on", {31'd0, irq}, 32'd1);
      bus_read(2'd3, d);
      chk("R7 winner code", d, vec_of(i + 1));
      chk("R8 byte stride", {24'd0, d[31:24]}, 32'((i + 1) * 4));
      chk("R8 half stride", {16'd0, d[31:16]}, 32'((i + 1) * 1024));
      bus_write(2'd2, 32'h0000_FFFF);
      @(negedge clk); @(negedge clk);
      chk("R6 irq off", {31'd0, irq}, 32'd0);
      bus_read(2'd3, d); chk("R7 empty code", d, 32'd0);
    end

    // R6/R7 enable sweep with all pending
    @(negedge clk); lines = ~lines; settle();
    for (int j = 0; j < N; j++) begin
      bus_write(2'd1, 32'(1) << j);
      @(negedge clk); @(negedge clk);
      bus_read(2'd3, d); chk("R7 enabled only", d, vec_of(j + 1));
      chk("R6 irq enabled", {31'd0, irq}, 32'd1);
    end
    bus_write(2'd1, 32'd0);
    @(negedge clk); @(negedge clk);
    chk("R6 irq all disabled", {31'd0, irq}, 32'd0);
    bus_read(2'd2, d); chk("R6 pending kept", d, 32'h0000_FFFF);
    bus_write(2'd2, 32'h0000_FFFF);

    // R9 vector frozen during a held read
    bus_write(2'd1, 32'h0000_FFFF);
    @(negedge clk); lines[10] = ~lines[10]; settle();
    @(negedge clk);
    sel = 1'b1; rd = 1'b1; addr = 2'd3;
    @(negedge clk);
    held = rdata;
    chk("R9 first value", held, vec_of(11));
    lines[2] = ~lines[2];
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      chk("R9 held stable", rdata, vec_of(11));
    end
    sel = 1'b0; rd = 1'b0;
    bus_read(2'd3, d); chk("R9 after release", d, vec_of(3));
    bus_write(2'd2, 32'h0000_FFFF);
    bus_write(2'd1, 32'd0);

    // R5 event coincides with clear
    @(negedge clk); lines[4] = ~lines[4]; lines[5] = ~lines[5]; settle();
    bus_read(2'd2, d); chk("R5 setup", d, 32'h30);
    @(negedge clk); lines[4] = ~lines[4];
    @(negedge clk);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = 2'd2; wdata = 32'h30;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
    bus_read(2'd2, d); chk("R5 event wins over clear", d, 32'h10);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule